// File: doc/BRIEF.md
# Overclock Recovery Watchdog

This block recovers a system that hangs after its clock frequency has been raised. Once enabled, it counts fixed-length ticks down from a programmed limit. A tick is nominally about 290 ms and comes from an internal prescaler whose division ratio is a parameter. Software restarts the window with a kick pulse, or by writing a new limit. If the window runs out, the block takes three actions in the same clock edge:

- It latches an alarm status.
- It overwrites the active 5-bit frequency selection with a stored safe code.
- It drives an active-low system reset low for a fixed number of clocks.

While the alarm is set, the block stops counting and forces the frequency source selection back to the hardware setting. The alarm stays set until software clears it or disables the watchdog. The limit register resets to 16 ticks, which is about 4.64 s at the nominal tick. The safe code uses the same encoding as the main frequency selection.

Top module: `ocwd_top`

## Requirements
- R1: After reset, alarm_o is 0, sys_rst_no is 1 and freq_code_o is 5'b00000. The limit register holds 16.
- R2: While enabled and not in alarm, expiry occurs exactly TICK_DIV×L clock edges after the last reload. L is the limit value. With the reset limit this is 16×TICK_DIV edges.
- R3: At expiry, freq_code_o takes the value present on safe_code_i at that edge.
- R4: sys_rst_no goes low at the expiry edge and stays low for exactly RST_LEN cycles, then returns high.
- R5: A kick_i pulse reloads the full window. A kick in the cycle of the final tick prevents that expiry.
- R6: A limit write (lim_wr_i) loads lim_i and restarts the window with the new value.
- R7: While wd_en_i is 0, the counter is held reloaded and no expiry can occur. After enabling, a full window elapses before expiry.
- R8: The alarm stays set while enabled until alarm_clr_i is pulsed. No further reset pulse occurs while in alarm. Deasserting wd_en_i also clears the alarm.
- R9: src_prog_o follows src_prog_i, except that it is forced to 0 while alarm_o is 1.
- R10: sel_wr_i loads sel_code_i into freq_code_o on the next edge. At an expiry edge, the safe code wins over a simultaneous write.
- R11: A limit of 0 expires at the first tick, the same as a limit of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wd_en_i | input | 1 | Watchdog enable |
| lim_wr_i | input | 1 | Limit register write strobe |
| lim_i | input | CNT_W | Limit value in ticks |
| kick_i | input | 1 | Restart pulse |
| alarm_clr_i | input | 1 | Clear alarm status |
| safe_code_i | input | FC_W | Safe frequency code |
| sel_wr_i | input | 1 | Active frequency selection write strobe |
| sel_code_i | input | FC_W | New active frequency code |
| src_prog_i | input | 1 | Requested frequency source (1 = programmed dividers) |
| alarm_o | output | 1 | Alarm status |
| freq_code_o | output | FC_W | Active frequency selection |
| src_prog_o | output | 1 | Effective frequency source |
| sys_rst_no | output | 1 | Active-low system reset pulse |

## Verification
Two functions can collide in one cycle: a restart (a kick or a limit write) and the final tick that would expire the window. A second collision is a frequency write arriving on the expiry edge. Directed cases place a kick exactly on the last tick, which must suppress the alarm. They also place a selection write on the expiry edge, where the safe code must appear. Random stimulus then scatters kicks, writes, clears and enable changes with short limits so that both collisions recur. A cycle-level bench model, built on counting cycles remaining in the window, judges every cycle.

// File: rtl/ocwd_pkg.sv
package ocwd_pkg;
  localparam int FC_W = 5;
  typedef logic [FC_W-1:0] fcode_t;
endpackage

// File: rtl/ocwd_tick_gen.sv
module ocwd_tick_gen #(
  parameter int TICK_DIV = 14_500_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic clear_i,
  output logic tick_o
);
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

  logic [PW-1:0] pre_q;

  assign tick_o = run_i && (pre_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 pre_q <= '0;
    else if (clear_i || !run_i)  pre_q <= '0;
    else if (pre_q == LAST)      pre_q <= '0;
    else                         pre_q <= pre_q + 1'b1;
  end

  // R7
  idle_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (pre_q == '0));
endmodule

// File: rtl/ocwd_countdown.sv
module ocwd_countdown #(
  parameter int CNT_W     = 8,
  parameter int LIMIT_RST = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             kick_i,
  input  logic             lim_wr_i,
  input  logic [CNT_W-1:0] lim_i,
  output logic             reload_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] lim_q, cnt_q;

  assign reload_o = lim_wr_i || kick_i || !run_i;
  // restart beats the final tick
  assign expire_o = run_i && tick_i && !reload_o && (cnt_q <= CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lim_q <= CNT_W'(LIMIT_RST);
      cnt_q <= CNT_W'(LIMIT_RST);
    end else if (lim_wr_i) begin
      lim_q <= lim_i;
      cnt_q <= lim_i;
    end else if (reload_o || expire_o) begin
      cnt_q <= lim_q;
    end else if (tick_i) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // R2
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= lim_q);
  // R6
  lim_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lim_wr_i |=> (cnt_q == $past(lim_i)));
endmodule

// File: rtl/ocwd_rst_pulse.sv
module ocwd_rst_pulse #(
  parameter int RST_LEN = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  output logic sys_rst_no
);
  localparam int RW = $clog2(RST_LEN + 1);
  logic [RW-1:0] left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           left_q <= '0;
    else if (fire_i)       left_q <= RW'(RST_LEN);
    else if (left_q != '0) left_q <= left_q - 1'b1;
  end

  assign sys_rst_no = (left_q == '0);

  // R4
  pulse_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    left_q <= RW'(RST_LEN));
endmodule

// File: rtl/ocwd_top.sv
module ocwd_top
  import ocwd_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int TICK_DIV  = 14_500_000,
  parameter int RST_LEN   = 16,
  parameter int LIMIT_RST = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wd_en_i,
  input  logic             lim_wr_i,
  input  logic [CNT_W-1:0] lim_i,
  input  logic             kick_i,
  input  logic             alarm_clr_i,
  input  logic [FC_W-1:0]  safe_code_i,
  input  logic             sel_wr_i,
  input  logic [FC_W-1:0]  sel_code_i,
  input  logic             src_prog_i,
  output logic             alarm_o,
  output logic [FC_W-1:0]  freq_code_o,
  output logic             src_prog_o,
  output logic             sys_rst_no
);
  logic   alarm_q, run, tick, reload, expire;
  fcode_t code_q;

  assign run = wd_en_i && !alarm_q;

  ocwd_tick_gen #(.TICK_DIV(TICK_DIV)) i_tick (
    .clk_i, .rst_ni, .run_i(run), .clear_i(reload), .tick_o(tick)
  );

  ocwd_countdown #(.CNT_W(CNT_W), .LIMIT_RST(LIMIT_RST)) i_cnt (
    .clk_i, .rst_ni, .run_i(run), .tick_i(tick), .kick_i,
    .lim_wr_i, .lim_i, .reload_o(reload), .expire_o(expire)
  );

  ocwd_rst_pulse #(.RST_LEN(RST_LEN)) i_pulse (
    .clk_i, .rst_ni, .fire_i(expire), .sys_rst_no
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      alarm_q <= 1'b0;
    else if (expire)                  alarm_q <= 1'b1;
    else if (alarm_clr_i || !wd_en_i) alarm_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       code_q <= '0;
    else if (expire)   code_q <= safe_code_i;
    else if (sel_wr_i) code_q <= sel_code_i;
  end

  assign alarm_o     = alarm_q;
  assign freq_code_o = code_q;
  assign src_prog_o  = src_prog_i && !alarm_q;

  // R4
  alarm_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(alarm_q) |-> !sys_rst_no);
  // R3
  safe_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(alarm_q) |-> (freq_code_o == $past(safe_code_i)));
  // R8
  alarm_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alarm_q && wd_en_i && !alarm_clr_i) |=> alarm_q);
  // R8
  no_refire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alarm_q && sys_rst_no) |=> sys_rst_no);
endmodule

// File: tb/test_ocwd_top.sv
module test_ocwd_top;
  localparam int D = 4;
  localparam int RL = 3;

  logic clk = 0, rst_n = 0;
  logic en = 0, lim_wr = 0, kick = 0, clr = 0, sel_wr = 0, src = 0;
  logic [7:0] lim = 0;
  logic [4:0] safe = 0, sel_code = 0;
  logic alarm, src_o, srst_n;
  logic [4:0] code;

  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  ocwd_top #(.CNT_W(8), .TICK_DIV(D), .RST_LEN(RL), .LIMIT_RST(16)) i_ocwd_top (
    .clk_i(clk), .rst_ni(rst_n), .wd_en_i(en), .lim_wr_i(lim_wr), .lim_i(lim),
    .kick_i(kick), .alarm_clr_i(clr), .safe_code_i(safe), .sel_wr_i(sel_wr),
    .sel_code_i(sel_code), .src_prog_i(src), .alarm_o(alarm),
    .freq_code_o(code), .src_prog_o(src_o), .sys_rst_no(srst_n)
  );

  // bench model: cycles remaining in the window
  int m_lim, m_rem, m_pul;
  logic m_alarm;
  logic [4:0] m_code;

  function automatic int win(input int l);
    return ((l == 0) ? 1 : l) * D;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_lim = 16; m_rem = win(16); m_pul = 0; m_alarm = 0; m_code = 0;
    end else begin
      logic run, exp_now;
      run = en && !m_alarm;
      exp_now = 0;
      if (lim_wr) begin m_lim = lim; m_rem = win(lim); end
      else if (kick || !run) m_rem = win(m_lim);
      else begin
        m_rem--;
        if (m_rem == 0) begin exp_now = 1; m_rem = win(m_lim); end
      end
      if (exp_now) m_pul = RL; else if (m_pul > 0) m_pul--;
      if (exp_now) m_alarm = 1; else if (clr || !en) m_alarm = 0;
      if (exp_now) m_code = safe; else if (sel_wr) m_code = sel_code;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic compare();
    chk(alarm == m_alarm, "R8 alarm", alarm, m_alarm);
    chk(srst_n == (m_pul == 0), "R4 reset", srst_n, m_pul == 0);
    chk(code == m_code, "R3/R10 code", code, m_code);
    chk(src_o == (src && !m_alarm), "R9 source", src_o, src && !m_alarm);
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    compare();
    lim_wr = 0; kick = 0; clr = 0; sel_wr = 0;
  endtask

  task automatic to_alarm(output int n);
    n = 0;
    for (int i = 0; i < 1000; i++) begin
      step(); n++;
      if (alarm) break;
    end
  endtask

  task automatic write_lim(input int l);
    lim = 8'(l); lim_wr = 1; step();
  endtask

  initial begin
    #(20 * 150000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int n, lowc;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk(alarm == 0, "R1 alarm", alarm, 0);
    chk(srst_n == 1, "R1 reset", srst_n, 1);
    chk(code == 0, "R1 code", code, 0);

    // R2 default limit 16, R3 safe code, R9 source
    safe = 5'd19; src = 1; en = 1;
    to_alarm(n);
    chk(n == 16 * D, "R2 default window", n, 16 * D);
    chk(code == 5'd19, "R3 safe code", code, 19);
    chk(src_o == 0, "R9 forced source", src_o, 0);
    // R4 pulse length
    lowc = 0;
    while (!srst_n && lowc < 50) begin lowc++; step(); end
    chk(lowc == RL, "R4 pulse length", lowc, RL);
    // R8 alarm holds, no refire
    lowc = 0;
    for (int i = 0; i < 100; i++) begin step(); if (!alarm || !srst_n) lowc++; end
    chk(lowc == 0, "R8 hold", lowc, 0);
    clr = 1; step();
    chk(alarm == 0, "R8 clear", alarm, 0);
    chk(src_o == 1, "R9 released", src_o, 1);

    // R5 kick on final tick
    write_lim(2);
    for (int i = 0; i < 2 * D - 1; i++) step();
    kick = 1; step();
    chk(alarm == 0, "R5 kick on last tick", alarm, 0);
    to_alarm(n);
    chk(n == 2 * D, "R5 window after kick", n, 2 * D);
    clr = 1; step();

    // R6 limit write restarts
    write_lim(3);
    for (int i = 0; i < 10; i++) step();
    write_lim(1);
    to_alarm(n);
    chk(n == D, "R6 new limit", n, D);
    clr = 1; step();

    // R7 disabled holds
    en = 0;
    for (int i = 0; i < 200; i++) step();
    chk(alarm == 0, "R7 disabled", alarm, 0);
    en = 1;
    to_alarm(n);
    chk(n == D, "R7 full window on enable", n, D);
    en = 0; step();
    chk(alarm == 0, "R8 disable clears", alarm, 0);
    en = 1;

    // R10 write then collision with expiry
    sel_code = 5'd7; sel_wr = 1; step();
    chk(code == 5'd7, "R10 write", code, 7);
    write_lim(1);
    for (int i = 0; i < D - 1; i++) step();
    safe = 5'd2; sel_code = 5'd30; sel_wr = 1; step();
    chk(alarm == 1, "R10 expiry edge", alarm, 1);
    chk(code == 5'd2, "R10 safe wins", code, 2);
    clr = 1; step();

    // R11 limit zero
    write_lim(0);
    to_alarm(n);
    chk(n == D, "R11 zero limit", n, D);
    clr = 1; step();

    // random phase
    for (int i = 0; i < 4000; i++) begin
      en       = ($urandom_range(0, 49) != 0);
      kick     = ($urandom_range(0, 9) == 0);
      lim_wr   = ($urandom_range(0, 29) == 0);
      lim      = 8'($urandom_range(0, 4));
      clr      = ($urandom_range(0, 19) == 0);
      sel_wr   = ($urandom_range(0, 9) == 0);
      sel_code = 5'($urandom);
      safe     = 5'($urandom);
      src      = 1'($urandom);
      step();
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule